// File: doc/BRIEF.md
# Fixed-Priority Memory Bus Arbiter

This block shares one memory bus among the five access classes that a processor core can raise: data write, program write, data read, program read and instruction fetch. Each class presents a request bit and an address. The two write classes also present write data. On every clock edge the arbiter picks exactly one winner by a fixed ranking tied to access type. It registers a one-hot grant and places the winner's address, write data and direction strobe on the bus. These all appear in the same cycle as the grant.

The arbiter keeps no queue. A class that loses keeps its request raised until it sees its own grant bit. The core never raises two particular pairs together: the two writes, and the program read with the fetch. If either pair does appear, the arbiter raises an error flag beside the grant and still serves the higher-ranked member, so the bus stays deterministic. When no class requests, the bus is idle. Both strobes are low and the address and data are zero.

Top module: `mem_bus_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `gnt_o`, `bus_rd_o`, `bus_wr_o`, `bus_addr_o`, `bus_wdata_o` and `conflict_o` are all zero.
- R2: Request and grant bit positions are: bit 0 data write, bit 1 program write, bit 2 data read, bit 3 program read, bit 4 instruction fetch. The lower bit index ranks higher. The grant goes to the lowest-indexed raised request.
- R3: At most one bit of `gnt_o` is high in any cycle.
- R4: All outputs are registered. They reflect the requests sampled at the preceding rising edge and do not change between edges.
- R5: `bus_addr_o` equals the address slice of the granted class, which is bits `[c*ADDR_W +: ADDR_W]` of `req_addr_i` for class index c.
- R6: A grant to class 0 or 1 raises `bus_wr_o` and drives that class's write data (`dw_wdata_i` or `pw_wdata_i`) onto `bus_wdata_o`. A grant to class 2, 3 or 4 raises `bus_rd_o` and drives `bus_wdata_o` to zero.
- R7: If no request is raised, the next cycle shows an idle bus: `gnt_o` is zero, both strobes are low, and address and write data are zero.
- R8: `conflict_o` is high in the cycle after a data write and a program write were requested together, or a program read and a fetch were requested together. In that case the higher-ranked member of the pair is still granted.
- R9: `bus_rd_o` and `bus_wr_o` are never high together, and one of them is high exactly when a grant bit is high.
- R10: A request that keeps losing gets no grant. Once every higher-ranked request drops, it is granted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request per class, bit 0 ranks highest |
| req_addr_i | input | 5*ADDR_W | Address per class, class c in slice c |
| dw_wdata_i | input | DATA_W | Data-write payload |
| pw_wdata_i | input | DATA_W | Program-write payload |
| gnt_o | output | 5 | Registered one-hot grant |
| bus_addr_o | output | ADDR_W | Bus address of the winner |
| bus_wdata_o | output | DATA_W | Bus write data, zero on reads and idle |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| conflict_o | output | 1 | Forbidden request pair seen |

## Verification
Random request vectors drawn from all 32 combinations test the ranking against every mix of rivals, including the forbidden pairs. Distinct random addresses and payloads per class make a wrong mux select visible as a wrong value. Directed cases test the idle bus, each class alone, both forbidden pairs and a low-ranked class starved until its rivals drop. Sampling just before an edge separates registered outputs from a combinational path.

// File: rtl/mba_pkg.sv
package mba_pkg;
  localparam int unsigned NCLS = 5;

  typedef enum logic [2:0] {
    CLS_DWR  = 3'd0,
    CLS_PWR  = 3'd1,
    CLS_DRD  = 3'd2,
    CLS_PRD  = 3'd3,
    CLS_FTCH = 3'd4
  } cls_e;

  localparam logic [NCLS-1:0] WRITE_MASK = 5'b00011;
  localparam logic [NCLS-1:0] READ_MASK  = 5'b11100;
endpackage

// File: rtl/mba_prio_pick.sv
module mba_prio_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign pick[i]   = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/mba_onehot_mux.sv
module mba_onehot_mux #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 16
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] din,
  output logic [W-1:0]   dout
);
  logic [W-1:0] acc [N+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_leg
    assign acc[i+1] = acc[i] | ({W{sel[i]}} & din[i*W +: W]);
  end

  assign dout = acc[N];
endmodule

// File: rtl/mba_conflict_det.sv
module mba_conflict_det
  import mba_pkg::*;
(
  input  logic [NCLS-1:0] req,
  output logic            bad
);
  logic write_pair;
  logic read_pair;

  assign write_pair = req[CLS_DWR] & req[CLS_PWR];
  assign read_pair  = req[CLS_PRD] & req[CLS_FTCH];
  assign bad        = write_pair | read_pair;
endmodule

// File: rtl/mem_bus_arbiter.sv
module mem_bus_arbiter
  import mba_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCLS-1:0]        req_i,
  input  logic [NCLS*ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]      dw_wdata_i,
  input  logic [DATA_W-1:0]      pw_wdata_i,
  output logic [NCLS-1:0]        gnt_o,
  output logic [ADDR_W-1:0]      bus_addr_o,
  output logic [DATA_W-1:0]      bus_wdata_o,
  output logic                   bus_rd_o,
  output logic                   bus_wr_o,
  output logic                   conflict_o
);
  localparam int unsigned WD_FLAT = NCLS * DATA_W;

  logic [NCLS-1:0]    pick;
  logic [ADDR_W-1:0]  addr_sel;
  logic [DATA_W-1:0]  wdata_sel;
  logic [WD_FLAT-1:0] wdata_flat;
  logic               bad_pair;

  // Only the write classes carry payload; read legs feed zero.
  always_comb begin
    wdata_flat = '0;
    wdata_flat[int'(CLS_DWR)*DATA_W +: DATA_W] = dw_wdata_i;
    wdata_flat[int'(CLS_PWR)*DATA_W +: DATA_W] = pw_wdata_i;
  end

  mba_prio_pick #(.N(NCLS)) u_pick (
    .req  (req_i),
    .pick (pick)
  );

  mba_onehot_mux #(.N(NCLS), .W(ADDR_W)) u_addr_mux (
    .sel  (pick),
    .din  (req_addr_i),
    .dout (addr_sel)
  );

  mba_onehot_mux #(.N(NCLS), .W(DATA_W)) u_wdata_mux (
    .sel  (pick),
    .din  (wdata_flat),
    .dout (wdata_sel)
  );

  mba_conflict_det u_conflict (
    .req (req_i),
    .bad (bad_pair)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o       <= '0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_rd_o    <= 1'b0;
      bus_wr_o    <= 1'b0;
      conflict_o  <= 1'b0;
    end else begin
      gnt_o       <= pick;
      bus_addr_o  <= addr_sel;
      bus_wdata_o <= wdata_sel;
      bus_rd_o    <= |(pick & READ_MASK);
      bus_wr_o    <= |(pick & WRITE_MASK);
      conflict_o  <= bad_pair;
    end
  end
endmodule

// File: rtl/mba_checker.sv
module mba_checker
  import mba_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NCLS-1:0]        req_i,
  input logic [NCLS-1:0]        gnt_o,
  input logic [ADDR_W-1:0]      bus_addr_o,
  input logic [DATA_W-1:0]      bus_wdata_o,
  input logic [DATA_W-1:0]      dw_wdata_i,
  input logic                   bus_rd_o,
  input logic                   bus_wr_o,
  input logic                   conflict_o
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd_o && bus_wr_o));

  p_strobe_grant_r9: assert property (@(posedge clk) disable iff (rst)
    ((|gnt_o) == (bus_rd_o || bus_wr_o)));

  p_top_wins_r2: assert property (@(posedge clk) disable iff (rst)
    req_i[CLS_DWR] |=> (gnt_o[CLS_DWR] && bus_wr_o && bus_wdata_o == $past(dw_wdata_i)));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0) |=> (gnt_o == '0 && !bus_rd_o && !bus_wr_o && bus_addr_o == '0));

  p_wpair_r8: assert property (@(posedge clk) disable iff (rst)
    (req_i[CLS_DWR] && req_i[CLS_PWR]) |=> (conflict_o && gnt_o[CLS_DWR]));

  p_rpair_r8: assert property (@(posedge clk) disable iff (rst)
    (req_i[CLS_PRD] && req_i[CLS_FTCH] && !(|req_i[2:0])) |=> (conflict_o && gnt_o[CLS_PRD]));

  p_read_zero_data_r6: assert property (@(posedge clk) disable iff (rst)
    bus_rd_o |-> (bus_wdata_o == '0));
endmodule

bind mem_bus_arbiter mba_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mba_checker (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .dw_wdata_i  (dw_wdata_i),
  .bus_rd_o    (bus_rd_o),
  .bus_wr_o    (bus_wr_o),
  .conflict_o  (conflict_o)
);

// File: tb/tb_mem_bus_arbiter.sv
`timescale 1ns/1ps
module tb_mem_bus_arbiter;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NC = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NC-1:0]   req_i = '0;
  logic [NC*AW-1:0] req_addr_i = '0;
  logic [DW-1:0]   dw_wdata_i = '0;
  logic [DW-1:0]   pw_wdata_i = '0;
  logic [NC-1:0]   gnt_o;
  logic [AW-1:0]   bus_addr_o;
  logic [DW-1:0]   bus_wdata_o;
  logic            bus_rd_o, bus_wr_o, conflict_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NC-1:0] e_gnt;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_wd;
  logic          e_rd, e_wr, e_cf;

  always #10 clk = ~clk;

  mem_bus_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .req_i(req_i), .req_addr_i(req_addr_i),
    .dw_wdata_i(dw_wdata_i), .pw_wdata_i(pw_wdata_i), .gnt_o(gnt_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .conflict_o(conflict_o)
  );

  function automatic logic [NC-1:0] model_gnt(input logic [NC-1:0] r);
    for (int i = 0; i < NC; i++) if (r[i]) return NC'(1) << i;
    return '0;
  endfunction

  task automatic compute_expect();
    e_gnt  = model_gnt(req_i);
    e_addr = '0; e_wd = '0; e_rd = 1'b0; e_wr = 1'b0;
    for (int i = 0; i < NC; i++) if (e_gnt[i]) begin
      e_addr = req_addr_i[i*AW +: AW];
      if (i < 2) begin e_wr = 1'b1; e_wd = (i == 0) ? dw_wdata_i : pw_wdata_i; end
      else e_rd = 1'b1;
    end
    e_cf = (req_i[0] & req_i[1]) | (req_i[3] & req_i[4]);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 grant"}, 64'(gnt_o), 64'(e_gnt));
    chk("R3 onehot", 64'($countones(gnt_o) <= 1), 64'(1));
    chk({tag, " R5 addr"}, 64'(bus_addr_o), 64'(e_addr));
    chk({tag, " R6 wdata"}, 64'(bus_wdata_o), 64'(e_wd));
    chk({tag, " R6 strobes"}, 64'({bus_rd_o, bus_wr_o}), 64'({e_rd, e_wr}));
    chk({tag, " R8 conflict"}, 64'(conflict_o), 64'(e_cf));
    chk("R9 strobe/grant", 64'({bus_rd_o & bus_wr_o, (bus_rd_o | bus_wr_o) == (|gnt_o)}), 64'(1));
  endtask

  // Drive at negedge; R4: outputs unchanged until the edge; then compare.
  task automatic step(input logic [NC-1:0] r, input string tag);
    logic [NC-1:0] prev_g;
    @(negedge clk);
    prev_g = gnt_o;
    req_i = r;
    compute_expect();
    #5;
    chk({tag, " R4 no comb path"}, 64'(gnt_o), 64'(prev_g));
    @(posedge clk); #1;
    check_all(tag);
  endtask

  task automatic randomize_data();
    for (int i = 0; i < NC; i++) req_addr_i[i*AW +: AW] = AW'($urandom);
    dw_wdata_i = DW'($urandom);
    pw_wdata_i = DW'($urandom);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    randomize_data();
    req_i = 5'b11111;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset gnt", 64'(gnt_o), 64'(0));
    chk("R1 reset bus", 64'({bus_addr_o, bus_wdata_o, bus_rd_o, bus_wr_o, conflict_o}), 64'(0));
    @(negedge clk); rst = 1'b0; req_i = '0;
    @(posedge clk); #1;
    chk("R1 first cycle", 64'({gnt_o, bus_rd_o, bus_wr_o, conflict_o}), 64'(0));

    // R7 idle
    step(5'b00000, "R7 idle");
    chk("R7 idle addr", 64'(bus_addr_o), 64'(0));
    // Single classes: R5, R6
    for (int c = 0; c < NC; c++) begin
      randomize_data();
      step(NC'(1) << c, "single");
    end
    // R8 forbidden pairs
    step(5'b00011, "R8 write pair");
    step(5'b11000, "R8 read pair");
    step(5'b11111, "R2 all");
    // R10 starvation of fetch, then release
    for (int k = 0; k < 4; k++) begin
      step(5'b10100, "R10 held");
      chk("R10 fetch starved", 64'(gnt_o[4]), 64'(0));
    end
    step(5'b10000, "R10 released");
    chk("R10 fetch granted", 64'(gnt_o[4]), 64'(1));
    step(5'b00000, "R7 back to idle");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      randomize_data();
      step(NC'($urandom), "random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule